// File: doc/BRIEF.md
# Configurable-flavour eight-line GPIO port

This block is an eight-line general-purpose I/O port for a board management controller. A single elaboration parameter builds it as one of three flavours. The bidirectional flavour has a direction byte, an output byte and an input byte. The input-only flavour has one read-only byte that returns the pin levels. The output-only flavour has one byte that holds the driven levels. Line n of the port is bit n of every register.

Software reaches the registers through a plain byte-wide register port. A write strobe stores the write data on a rising clock edge. Read data is a combinational function of the address. The pin side has three vectors: sampled levels come in, driven levels go out, and a per-line output enable goes out. Incoming levels pass through a two-flop synchroniser before any register can return them.

Reset is asynchronous and active low. Inside the block its release is delayed by two clock edges.

Top module: `gpio_port`

## Requirements
- R1: In the bidirectional flavour, offset 0x00 is the direction byte and offset 0x01 is the output byte. Both are written by a write strobe and read back unchanged from the first edge after the write.
- R2: In the bidirectional flavour, a direction bit of 1 makes its line an output (`pin_oe_o` bit n is 1) and a bit of 0 makes it an input. Line n is bit n.
- R3: In the bidirectional and output-only flavours, `pin_out_o` drives the value held in the output byte.
- R4: In the bidirectional flavour, offset 0x02 returns the synchronised pin levels whatever the direction byte holds.
- R5: A pin level change set up before a rising edge is not readable after that edge. It is readable after the second rising edge.
- R6: In the input-only flavour, offset 0x00 returns the synchronised pin levels and writes to it are ignored. `pin_out_o` and `pin_oe_o` are always 0x00.
- R7: In the output-only flavour, offset 0x00 holds the driven value and reads return the last value written. `pin_oe_o` is 0xFF.
- R8: In every flavour, reads from an offset the flavour does not define return 0x00. Writes to such offsets change no state.
- R9: After reset, every direction bit is 0 (input) and every output bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_addr_i | input | 8 | Register offset |
| reg_wr_i | input | 1 | Write strobe, one cycle per write |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the current offset |
| pin_in_i | input | 8 | Pin levels, asynchronous |
| pin_out_o | output | 8 | Driven pin levels |
| pin_oe_o | output | 8 | Per-line output enable |

## Verification
The register-side assertions take it for granted that the address, write strobe and write data are known and settled at each rising edge. They also assume a write strobe lasts exactly the cycle of its write. The pin inputs may change at any time. The synchroniser check compares only against levels sampled after reset. The stimulus changes the bus signals only on falling edges, raises the write strobe for a single cycle, and moves pin levels only on falling edges, so that the exact two-edge latency can be observed.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
package gpio_port_pkg;

  typedef enum logic [1:0] {
    FLAV_BIDIR    = 2'd0,
    FLAV_IN_ONLY  = 2'd1,
    FLAV_OUT_ONLY = 2'd2
  } gpio_flavour_e;

  // bidirectional map
  localparam int unsigned OFS_DIR  = 0;
  localparam int unsigned OFS_OUT  = 1;
  localparam int unsigned OFS_IN   = 2;
  // single-register flavours
  localparam int unsigned OFS_SOLO = 0;

endpackage

// File: rtl/gpio_rst_sync.sv
`timescale 1ns/1ps
module gpio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_sync_no = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] sync_o
);

  localparam int unsigned CNT_W = $clog2(STAGES + 1);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (g == 0) begin : g_first
      always_comb stage_d = pin_i;
    end else begin : g_next
      always_comb stage_d = stage_q[g-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[g] <= '0;
      else         stage_q[g] <= stage_d;
    end
  end

  assign sync_o = stage_q[STAGES-1];

  // edges seen since reset, saturating at STAGES
  logic [CNT_W-1:0] seen_q;
  logic [CNT_W-1:0] seen_d;
  logic             seen_en;

  always_comb begin
    seen_en = (seen_q != CNT_W'(STAGES));
    seen_d  = seen_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      seen_q <= '0;
    else if (seen_en) seen_q <= seen_d;
  end

  if (STAGES == 2) begin : g_chk
    // R5: output lags the pin by exactly two edges
    assert_sync_delay_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seen_q == CNT_W'(STAGES)) |-> (sync_o == $past(pin_i, 2)));
  end

endmodule

// File: rtl/gpio_reg_file.sv
`timescale 1ns/1ps
module gpio_reg_file
  import gpio_port_pkg::*;
#(
  parameter gpio_flavour_e FLAVOUR = FLAV_BIDIR,
  parameter int unsigned   WIDTH   = 8,
  parameter int unsigned   ADDR_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  dir_o,
  output logic [WIDTH-1:0]  out_o
);

  if (FLAVOUR == FLAV_BIDIR) begin : g_bidir
    logic             dir_en, out_en;
    logic [WIDTH-1:0] dir_d, out_d;
    logic [WIDTH-1:0] dir_q, out_q;

    always_comb begin
      dir_en = wr_i && (addr_i == ADDR_W'(OFS_DIR));
      out_en = wr_i && (addr_i == ADDR_W'(OFS_OUT));
      dir_d  = wdata_i;
      out_d  = wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        dir_q <= '0;
        out_q <= '0;
      end else begin
        if (dir_en) dir_q <= dir_d;
        if (out_en) out_q <= out_d;
      end
    end

    assign dir_o = dir_q;
    assign out_o = out_q;

    assert_dir_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && addr_i == ADDR_W'(OFS_DIR)) |=> (dir_q == $past(wdata_i)));
    assert_out_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && addr_i == ADDR_W'(OFS_OUT)) |=> (out_q == $past(wdata_i)));
    assert_dir_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_i && addr_i == ADDR_W'(OFS_DIR)) |=> $stable(dir_q));
    assert_out_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_i && addr_i == ADDR_W'(OFS_OUT)) |=> $stable(out_q));

  end else if (FLAVOUR == FLAV_OUT_ONLY) begin : g_out
    logic             solo_en;
    logic [WIDTH-1:0] solo_d;
    logic [WIDTH-1:0] solo_q;

    always_comb begin
      solo_en = wr_i && (addr_i == ADDR_W'(OFS_SOLO));
      solo_d  = wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      solo_q <= '0;
      else if (solo_en) solo_q <= solo_d;
    end

    assign dir_o = '1;
    assign out_o = solo_q;

    assert_solo_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && addr_i == ADDR_W'(OFS_SOLO)) |=> (solo_q == $past(wdata_i)));
    assert_solo_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_i && addr_i == ADDR_W'(OFS_SOLO)) |=> $stable(solo_q));

  end else begin : g_in
    // no writable state at all
    assign dir_o = '0;
    assign out_o = '0;
  end

endmodule

// File: rtl/gpio_rd_mux.sv
`timescale 1ns/1ps
module gpio_rd_mux
  import gpio_port_pkg::*;
#(
  parameter gpio_flavour_e FLAVOUR = FLAV_BIDIR,
  parameter int unsigned   WIDTH   = 8,
  parameter int unsigned   ADDR_W  = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  dir_i,
  input  logic [WIDTH-1:0]  out_i,
  input  logic [WIDTH-1:0]  in_i,
  output logic [WIDTH-1:0]  rdata_o
);

  if (FLAVOUR == FLAV_BIDIR) begin : g_bidir
    always_comb begin
      if (addr_i == ADDR_W'(OFS_DIR))      rdata_o = dir_i;
      else if (addr_i == ADDR_W'(OFS_OUT)) rdata_o = out_i;
      else if (addr_i == ADDR_W'(OFS_IN))  rdata_o = in_i;
      else                                 rdata_o = '0;
    end
  end else if (FLAVOUR == FLAV_OUT_ONLY) begin : g_out
    logic [WIDTH-1:0] unused_mix;
    always_comb unused_mix = dir_i ^ in_i;
    always_comb rdata_o = (addr_i == ADDR_W'(OFS_SOLO)) ? out_i : '0;
  end else begin : g_in
    logic [WIDTH-1:0] unused_mix;
    always_comb unused_mix = dir_i ^ out_i;
    always_comb rdata_o = (addr_i == ADDR_W'(OFS_SOLO)) ? in_i : '0;
  end

endmodule

// File: rtl/gpio_port.sv
`timescale 1ns/1ps
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter gpio_flavour_e FLAVOUR     = FLAV_BIDIR,
  parameter int unsigned   WIDTH       = 8,
  parameter int unsigned   ADDR_W      = 8,
  parameter int unsigned   SYNC_STAGES = 2,
  parameter int unsigned   RST_STAGES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [WIDTH-1:0]  reg_wdata_i,
  output logic [WIDTH-1:0]  reg_rdata_o,
  input  logic [WIDTH-1:0]  pin_in_i,
  output logic [WIDTH-1:0]  pin_out_o,
  output logic [WIDTH-1:0]  pin_oe_o
);

  logic             rst_sync_n;
  logic [WIDTH-1:0] pins_sync;
  logic [WIDTH-1:0] dir_w;
  logic [WIDTH-1:0] out_w;

  gpio_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .pin_i  (pin_in_i),
    .sync_o (pins_sync)
  );

  gpio_reg_file #(.FLAVOUR(FLAVOUR), .WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .wr_i    (reg_wr_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .dir_o   (dir_w),
    .out_o   (out_w)
  );

  gpio_rd_mux #(.FLAVOUR(FLAVOUR), .WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_rd (
    .addr_i  (reg_addr_i),
    .dir_i   (dir_w),
    .out_i   (out_w),
    .in_i    (pins_sync),
    .rdata_o (reg_rdata_o)
  );

  assign pin_out_o = out_w;
  assign pin_oe_o  = dir_w;

  if (FLAVOUR == FLAV_BIDIR) begin : g_chk_bidir
    assert_oe_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
      (reg_wr_i && reg_addr_i == ADDR_W'(OFS_DIR)) |=> (pin_oe_o == $past(reg_wdata_i)));
    assert_drive_R3: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
      (reg_wr_i && reg_addr_i == ADDR_W'(OFS_OUT)) |=> (pin_out_o == $past(reg_wdata_i)));
    assert_undef_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
      (reg_addr_i > ADDR_W'(OFS_IN)) |-> (reg_rdata_o == '0));
    assert_reset_state_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rst_sync_n) |-> (pin_oe_o == '0 && pin_out_o == '0));
  end else if (FLAVOUR == FLAV_OUT_ONLY) begin : g_chk_out
    assert_drive_R3: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
      (reg_wr_i && reg_addr_i == ADDR_W'(OFS_SOLO)) |=> (pin_out_o == $past(reg_wdata_i)));
    assert_undef_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
      (reg_addr_i != ADDR_W'(OFS_SOLO)) |-> (reg_rdata_o == '0));
    assert_reset_state_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rst_sync_n) |-> (pin_out_o == '0));
  end else begin : g_chk_in
    assert_undef_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
      (reg_addr_i != ADDR_W'(OFS_SOLO)) |-> (reg_rdata_o == '0));
    assert_in_read_R6: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
      (reg_addr_i == ADDR_W'(OFS_SOLO)) |-> (reg_rdata_o == pins_sync));
  end

endmodule

// File: tb/gpio_port_tb_top.sv
`timescale 1ns/1ps
module gpio_port_tb_top;
  import gpio_port_pkg::*;

  localparam int BIDIR = 0;
  localparam int INO   = 1;
  localparam int OUTO  = 2;
  localparam int K_RD  = 0;
  localparam int K_PO  = 1;
  localparam int K_OE  = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic [2:0] wr = 3'b000;
  logic [7:0] pins = 8'h00;
  logic [7:0] rd_a [3];
  logic [7:0] po_a [3];
  logic [7:0] oe_a [3];

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    int         sel;
    int         kind;
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb_q [$];

  always #10 clk = ~clk;

  gpio_port #(.FLAVOUR(FLAV_BIDIR)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wr_i(wr[0]),
    .reg_wdata_i(wdata), .reg_rdata_o(rd_a[0]), .pin_in_i(pins),
    .pin_out_o(po_a[0]), .pin_oe_o(oe_a[0]));

  gpio_port #(.FLAVOUR(FLAV_IN_ONLY)) dut_in_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wr_i(wr[1]),
    .reg_wdata_i(wdata), .reg_rdata_o(rd_a[1]), .pin_in_i(pins),
    .pin_out_o(po_a[1]), .pin_oe_o(oe_a[1]));

  gpio_port #(.FLAVOUR(FLAV_OUT_ONLY)) dut_out_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wr_i(wr[2]),
    .reg_wdata_i(wdata), .reg_rdata_o(rd_a[2]), .pin_in_i(pins),
    .pin_out_o(po_a[2]), .pin_oe_o(oe_a[2]));

  // driver side: queue an expectation for the current cycle
  task automatic chk(input int sel, input int kind, input logic [7:0] a,
                     input logic [7:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    addr = a;
    #2;
    it.sel = sel; it.kind = kind; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic wr_reg(input int sel, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr[sel] = 1'b1;
    @(negedge clk);
    wr = 3'b000;
  endtask

  // monitor: pops and compares away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      #5;
      while (sb_q.size() > 0) begin
        item_t      it;
        logic [7:0] act;
        it = sb_q.pop_front();
        case (it.kind)
          K_RD:    act = rd_a[it.sel];
          K_PO:    act = po_a[it.sel];
          default: act = oe_a[it.sel];
        endcase
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s: actual %02h expected %02h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 reset state
    chk(BIDIR, K_RD, 8'h00, 8'h00, "R9 dir after reset");
    chk(BIDIR, K_RD, 8'h01, 8'h00, "R9 out after reset");
    chk(BIDIR, K_OE, 8'h00, 8'h00, "R9 oe after reset");
    chk(BIDIR, K_PO, 8'h00, 8'h00, "R9 pin_out after reset");
    chk(OUTO,  K_PO, 8'h00, 8'h00, "R9 out-only pin_out after reset");

    // R1 map and readback
    wr_reg(BIDIR, 8'h00, 8'h3C);
    wr_reg(BIDIR, 8'h01, 8'hA5);
    chk(BIDIR, K_RD, 8'h00, 8'h3C, "R1 dir readback");
    chk(BIDIR, K_RD, 8'h01, 8'hA5, "R1 out readback");

    // R2 direction -> output enable
    chk(BIDIR, K_OE, 8'h00, 8'h3C, "R2 oe pattern 3C");
    wr_reg(BIDIR, 8'h00, 8'h01);
    chk(BIDIR, K_OE, 8'h00, 8'h01, "R2 line0 only");
    wr_reg(BIDIR, 8'h00, 8'h80);
    chk(BIDIR, K_OE, 8'h00, 8'h80, "R2 line7 only");

    // R3 output drive
    chk(BIDIR, K_PO, 8'h00, 8'hA5, "R3 bidir pin_out");
    wr_reg(OUTO, 8'h00, 8'h5A);
    chk(OUTO, K_PO, 8'h00, 8'h5A, "R3 out-only pin_out");

    // R7 output-only register
    chk(OUTO, K_RD, 8'h00, 8'h5A, "R7 readback 5A");
    chk(OUTO, K_OE, 8'h00, 8'hFF, "R7 oe all ones");
    wr_reg(OUTO, 8'h00, 8'h81);
    chk(OUTO, K_RD, 8'h00, 8'h81, "R7 readback 81");

    // R4 input reflects pins whatever the direction
    @(negedge clk); pins = 8'h96;
    repeat (3) @(negedge clk);
    wr_reg(BIDIR, 8'h00, 8'hFF);
    chk(BIDIR, K_RD, 8'h02, 8'h96, "R4 input with all outputs");
    wr_reg(BIDIR, 8'h00, 8'h00);
    chk(BIDIR, K_RD, 8'h02, 8'h96, "R4 input with all inputs");

    // R5 two-edge synchroniser latency
    @(negedge clk); pins = 8'h4B;
    chk(INO, K_RD, 8'h00, 8'h96, "R5 one edge still old");
    chk(INO, K_RD, 8'h00, 8'h4B, "R5 two edges new");
    chk(BIDIR, K_RD, 8'h02, 8'h4B, "R5 bidir input new");

    // R6 input-only
    wr_reg(INO, 8'h00, 8'hA5);
    chk(INO, K_RD, 8'h00, 8'h4B, "R6 write ignored");
    chk(INO, K_PO, 8'h00, 8'h00, "R6 pin_out zero");
    chk(INO, K_OE, 8'h00, 8'h00, "R6 oe zero");

    // R8 undefined offsets
    chk(BIDIR, K_RD, 8'h03, 8'h00, "R8 bidir offset 03");
    chk(BIDIR, K_RD, 8'hFF, 8'h00, "R8 bidir offset FF");
    wr_reg(BIDIR, 8'h00, 8'h0F);
    wr_reg(BIDIR, 8'h07, 8'hEE);
    chk(BIDIR, K_RD, 8'h00, 8'h0F, "R8 dir untouched");
    chk(BIDIR, K_RD, 8'h01, 8'hA5, "R8 out untouched");
    chk(OUTO, K_RD, 8'h01, 8'h00, "R8 out-only offset 01");
    chk(INO,  K_RD, 8'h05, 8'h00, "R8 in-only offset 05");
    wr_reg(OUTO, 8'h01, 8'h33);
    chk(OUTO, K_PO, 8'h00, 8'h81, "R8 out-only stray write");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule